// File: doc/BRIEF.md
# Power Management Timer and Event Block

This block keeps the power management counter and the event registers of a system's power management function. A free-running counter advances by one on each cycle where the tick-enable input is high. The tick input is driven at 3.579545 MHz. Each time the counter's top bit toggles, a sticky overflow flag is raised. The real-time-clock, power-button and global events arrive as single-cycle input pulses, and each one sets its own sticky status bit. A level system control interrupt (SCI) output is high while any enabled event is pending.

Software uses a 16-bit register port with a 32-bit read path to clear status bits, program the enables and write the control register. A control write with the suspend bit set requests a sleep. Suspend type zero gives a one-cycle soft power-off request. A separate byte port holds an APM command byte and an APM status byte. A command write gives a one-cycle system management interrupt (SMI) pulse when the configuration enable input is high.

Top module: `pm_event_block`

## Requirements
- R1: The counter is CNT_W bits wide (default 24). It resets to zero, adds one on every cycle with `tick` high and wraps to zero. It holds its value when `tick` is low. A read at offset 0x08 returns it zero-extended to 32 bits.
- R2: Status bit 0 becomes 1 on the tick that makes the counter equal the pending overflow point. After reset that point is 2^(CNT_W-1). The bit then stays 1 until software clears it.
- R3: Writing status with bit 0 set while status bit 0 is 1 clears it. The write also moves the overflow point to the next multiple of 2^(CNT_W-1) above the current count, modulo 2^CNT_W. If the tick in the same cycle reaches that new point, the bit reads 1.
- R4: Input pulses `rtc_evt`, `pwrbtn_evt` and `gbl_evt` set status bits 10, 8 and 5. Writing 1 to one of these bits at offset 0x00 clears it, and writing 0 leaves it unchanged. An event pulse in the same cycle as a clear leaves the bit set. Other status bits read 0.
- R5: `sci` is high exactly when status AND enable is non-zero in at least one of bits 10, 8, 5 and 0. Enable bits at other positions have no effect on `sci`.
- R6: A write at offset 0x04 stores all 16 bits except bit 13, which always reads 0. Bit 0 of this register is the SCI enable bit, and it is stored and read back.
- R7: A write at offset 0x04 with bit 13 set and bits 11:10 equal to 0 raises `soft_off` for exactly one cycle, in the cycle after the write. Other suspend types and writes with bit 13 clear leave `soft_off` low.
- R8: A write on the APM port with `apm_sel`=0 stores the command byte. If `smi_cfg_en` is high it also raises `smi` for one cycle after the write. A write with `apm_sel`=1 stores the status byte and gives no SMI. `apm_rdata` returns the byte chosen by `apm_sel`.
- R9: Offset 0x02 holds the 16-bit enable register. Reads at offsets other than 0x00, 0x02, 0x04 and 0x08 return zero. Writes at 0x08 or at unmapped offsets change no state.
- R10: After reset the status, enable and control registers, both APM bytes, `sci`, `smi` and `soft_off` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| rtc_evt | input | 1 | Real-time-clock event pulse |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| gbl_evt | input | 1 | Global event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data for the current offset |
| sci | output | 1 | System control interrupt level |
| soft_off | output | 1 | Soft power-off request pulse |
| apm_wr | input | 1 | APM byte write strobe |
| apm_sel | input | 1 | 0 selects the command byte, 1 selects the status byte |
| apm_wdata | input | 8 | APM write byte |
| smi_cfg_en | input | 1 | Configuration enable for SMI on command writes |
| apm_rdata | output | 8 | Selected APM byte |
| smi | output | 1 | System management interrupt pulse |

## Verification
The assertions check a number of cycle-local relations on every cycle:
- the counter steps by one on a tick and holds without one;
- the overflow flag stays set until a clear and never rises without a tick;
- an event pulse always leaves its status bit set, and a clear without a pulse leaves it cleared;
- `sci` never rises while the relevant enables are zero;
- `soft_off` and `smi` follow exactly the writes that cause them, and the stored control word never keeps bit 13.

Two behaviours depend on a sequence of operations, and only the bench's scenarios show them. The first is where the overflow point moves after a clear, including a clear on the tick that reaches the new point. The second is the full read map compared against a reference model over long random runs.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int BIT_TMR  = 0;
    localparam int BIT_GBL  = 5;
    localparam int BIT_PWR  = 8;
    localparam int BIT_RTC  = 10;
    localparam int BIT_SUSP = 13;
    localparam int SUSP_LO  = 10;

    localparam logic [15:0] SCI_MASK = 16'h0521;
    localparam logic [15:0] EVT_MASK = 16'h0520;

    localparam int OFF_STS  = 0;
    localparam int OFF_EN   = 2;
    localparam int OFF_CTRL = 4;
    localparam int OFF_TMR  = 8;

    typedef struct packed {
        logic [15:0] sts;
        logic [15:0] en;
        logic [15:0] ctrl;
        logic        off;
    } pm_state_t;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] stat;
        logic       smi;
    } apm_state_t;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-2:0] LOW_ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tgt_hi;
        logic             sts;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (tick) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        if (clr && tmr_q.sts) begin
            tmr_d.sts    = 1'b0;
            tmr_d.tgt_hi = ~tmr_q.cnt[CNT_W-1];
        end
        if (tick && (tmr_d.cnt == {tmr_d.tgt_hi, LOW_ZERO})) begin
            tmr_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt    <= '0;
            tmr_q.tgt_hi <= 1'b1;
            tmr_q.sts    <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count = tmr_q.cnt;
    assign ovf   = tmr_q.sts;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == $past(count) + 1'b1);
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    assert_ovf_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !tick) |=> !ovf);
    assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ovf && !(tick && (&count[CNT_W-2:0]))) |=> !ovf);
endmodule

// File: rtl/pm_apm.sv
module pm_apm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       sel,
    input  logic [7:0] wdata,
    input  logic       smi_en,
    output logic [7:0] rdata,
    output logic       smi
);
    apm_state_t apm_q, apm_d;

    always_comb begin
        apm_d     = apm_q;
        apm_d.smi = 1'b0;
        if (wr && !sel) begin
            apm_d.cmd = wdata;
            apm_d.smi = smi_en;
        end
        if (wr && sel) begin
            apm_d.stat = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apm_q <= '0;
        end else begin
            apm_q <= apm_d;
        end
    end

    assign rdata = sel ? apm_q.stat : apm_q.cmd;
    assign smi   = apm_q.smi;

    assert_smi_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel && smi_en) |=> smi);
    assert_smi_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !sel && smi_en) |=> !smi);
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
    import pm_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rtc_evt,
    input  logic              pwrbtn_evt,
    input  logic              gbl_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sci,
    output logic              soft_off,
    input  logic              apm_wr,
    input  logic              apm_sel,
    input  logic [7:0]        apm_wdata,
    input  logic              smi_cfg_en,
    output logic [7:0]        apm_rdata,
    output logic              smi
);
    pm_state_t pm_q, pm_d;

    logic             hit_sts, hit_en, hit_ctrl, hit_tmr;
    logic             susp_req;
    logic [15:0]      clr_mask, evt_vec, sts_view;
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_ovf;

    assign hit_sts  = (reg_addr == ADDR_W'(OFF_STS));
    assign hit_en   = (reg_addr == ADDR_W'(OFF_EN));
    assign hit_ctrl = (reg_addr == ADDR_W'(OFF_CTRL));
    assign hit_tmr  = (reg_addr == ADDR_W'(OFF_TMR));
    assign clr_mask = (reg_wr && hit_sts) ? reg_wdata : 16'h0000;
    assign susp_req = reg_wr && hit_ctrl && reg_wdata[BIT_SUSP]
                      && (reg_wdata[SUSP_LO +: 2] == 2'b00);

    always_comb begin
        evt_vec          = '0;
        evt_vec[BIT_RTC] = rtc_evt;
        evt_vec[BIT_PWR] = pwrbtn_evt;
        evt_vec[BIT_GBL] = gbl_evt;
    end

    pm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (clr_mask[BIT_TMR]),
        .count (tmr_count),
        .ovf   (tmr_ovf)
    );

    pm_apm u_apm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (apm_wr),
        .sel    (apm_sel),
        .wdata  (apm_wdata),
        .smi_en (smi_cfg_en),
        .rdata  (apm_rdata),
        .smi    (smi)
    );

    always_comb begin
        pm_d     = pm_q;
        pm_d.off = susp_req;
        pm_d.sts = ((pm_q.sts & ~clr_mask) | evt_vec) & EVT_MASK;
        if (reg_wr && hit_en) begin
            pm_d.en = reg_wdata;
        end
        if (reg_wr && hit_ctrl) begin
            pm_d.ctrl           = reg_wdata;
            pm_d.ctrl[BIT_SUSP] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q <= '0;
        end else begin
            pm_q <= pm_d;
        end
    end

    always_comb begin
        sts_view          = pm_q.sts;
        sts_view[BIT_TMR] = tmr_ovf;
    end

    assign sci      = |(sts_view & pm_q.en & SCI_MASK);
    assign soft_off = pm_q.off;

    always_comb begin
        reg_rdata = '0;
        if (hit_sts) begin
            reg_rdata[15:0] = sts_view;
        end else if (hit_en) begin
            reg_rdata[15:0] = pm_q.en;
        end else if (hit_ctrl) begin
            reg_rdata[15:0] = pm_q.ctrl;
        end else if (hit_tmr) begin
            reg_rdata[CNT_W-1:0] = tmr_count;
        end
    end

    assert_rtc_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_evt |=> pm_q.sts[BIT_RTC]);
    assert_pwr_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_evt |=> pm_q.sts[BIT_PWR]);
    assert_gbl_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_sts && reg_wdata[BIT_GBL] && !gbl_evt) |=> !pm_q.sts[BIT_GBL]);
    assert_sci_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> ((pm_q.en & SCI_MASK) != 16'h0000));
    assert_susp_not_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_q.ctrl[BIT_SUSP]);
    assert_soft_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |=> soft_off);
    assert_soft_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_req |=> !soft_off);
endmodule

// File: tb/pm_event_block_test.sv
module pm_event_block_test;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 6;
    localparam int MOD    = 1 << CNT_W;
    localparam int HALF   = 1 << (CNT_W - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              rtc_evt = 1'b0, pwrbtn_evt = 1'b0, gbl_evt = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              sci, soft_off, smi;
    logic              apm_wr = 1'b0, apm_sel = 1'b0, smi_cfg_en = 1'b0;
    logic [7:0]        apm_wdata = '0;
    logic [7:0]        apm_rdata;

    int vectors = 0;
    int fails   = 0;

    int unsigned m_cnt, m_tgt;
    logic [15:0] m_sts, m_en, m_ctrl;
    logic [7:0]  m_cmd, m_stat;
    logic        m_smi, m_off;

    always #4 clk = ~clk;

    pm_event_block #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .rtc_evt(rtc_evt), .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sci(sci), .soft_off(soft_off),
        .apm_wr(apm_wr), .apm_sel(apm_sel), .apm_wdata(apm_wdata),
        .smi_cfg_en(smi_cfg_en), .apm_rdata(apm_rdata), .smi(smi)
    );

    task automatic model_reset();
        m_cnt = 0; m_tgt = HALF; m_sts = '0; m_en = '0; m_ctrl = '0;
        m_cmd = '0; m_stat = '0; m_smi = 1'b0; m_off = 1'b0;
    endtask

    task automatic model_step();
        int unsigned nxt;
        logic [15:0] clr;
        nxt = tick ? (m_cnt + 1) % MOD : m_cnt;
        clr = (reg_wr && reg_addr == 6'd0) ? reg_wdata : 16'h0;
        if (clr[0] && m_sts[0]) begin
            m_sts[0] = 1'b0;
            m_tgt = ((m_cnt / HALF + 1) * HALF) % MOD;
        end
        if (tick && nxt == m_tgt) m_sts[0] = 1'b1;
        m_sts[10] = (m_sts[10] & ~clr[10]) | rtc_evt;
        m_sts[8]  = (m_sts[8] & ~clr[8]) | pwrbtn_evt;
        m_sts[5]  = (m_sts[5] & ~clr[5]) | gbl_evt;
        m_off = 1'b0;
        if (reg_wr && reg_addr == 6'd2) m_en = reg_wdata;
        if (reg_wr && reg_addr == 6'd4) begin
            m_ctrl = reg_wdata & 16'hDFFF;
            m_off  = reg_wdata[13] && (reg_wdata[11:10] == 2'b00);
        end
        m_smi = 1'b0;
        if (apm_wr && !apm_sel) begin m_cmd = apm_wdata; m_smi = smi_cfg_en; end
        if (apm_wr && apm_sel) m_stat = apm_wdata;
        m_cnt = nxt;
    endtask

    function automatic logic [31:0] exp_rd(logic [ADDR_W-1:0] a);
        case (a)
            6'd0:    return {16'h0, m_sts};
            6'd2:    return {16'h0, m_en};
            6'd4:    return {16'h0, m_ctrl};
            6'd8:    return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(logic [ADDR_W-1:0] a);
        case (a)
            6'd0:    return "R4";
            6'd4:    return "R6";
            6'd8:    return "R1";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        chk(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
        chk("R5", {31'b0, sci}, {31'b0, |(m_sts & m_en & 16'h0521)});
        chk("R7", {31'b0, soft_off}, {31'b0, m_off});
        chk("R8", {31'b0, smi}, {31'b0, m_smi});
        chk("R8", {24'b0, apm_rdata}, {24'b0, apm_sel ? m_stat : m_cmd});
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        rtc_evt = 0; pwrbtn_evt = 0; gbl_evt = 0; reg_wr = 0; apm_wr = 0;
    endtask

    task automatic wr_reg(logic [ADDR_W-1:0] a, logic [15:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state through every port
        for (int a = 0; a <= 8; a += 2) begin
            reg_addr = 6'(a); #1;
            chk("R10", reg_rdata, 32'h0);
        end
        chk("R10", {29'b0, sci, smi, soft_off}, 32'h0);
        chk("R10", {24'b0, apm_rdata}, 32'h0);
        reg_addr = 6'd8;

        // R1: counting and holding
        tick = 1'b1;
        repeat (20) cyc();
        tick = 1'b0;
        repeat (5) cyc();
        chk("R1", reg_rdata, 32'd20);

        // R2: first overflow at HALF, sticky
        tick = 1'b1;
        while (m_cnt != HALF + 3) cyc();
        reg_addr = 6'd0; #1;
        chk("R2", reg_rdata & 32'h1, 32'h1);
        repeat (10) cyc();
        chk("R2", reg_rdata & 32'h1, 32'h1);

        // R3: clear and next point at wrap
        wr_reg(6'd0, 16'h0001);
        chk("R3", reg_rdata & 32'h1, 32'h0);
        while (m_cnt != 2) cyc();
        chk("R3", reg_rdata & 32'h1, 32'h1);
        // R3: clear on the tick that reaches the new point
        while (m_cnt != HALF - 1) cyc();
        wr_reg(6'd0, 16'h0001);
        chk("R3", reg_rdata & 32'h1, 32'h1);
        tick = 1'b0;
        wr_reg(6'd0, 16'h0001);
        chk("R3", reg_rdata & 32'h1, 32'h0);

        // R4/R5: events, enables, clears
        wr_reg(6'd2, 16'hFADE & ~16'h0521);
        rtc_evt = 1; pwrbtn_evt = 1; gbl_evt = 1; cyc(); quiet();
        chk("R5", {31'b0, sci}, 32'h0);
        wr_reg(6'd2, 16'h0100);
        chk("R5", {31'b0, sci}, 32'h1);
        wr_reg(6'd0, 16'h0000);
        chk("R4", reg_rdata, 32'h0520);
        gbl_evt = 1; reg_addr = 6'd0; reg_wdata = 16'h0020; reg_wr = 1; cyc(); quiet();
        chk("R4", reg_rdata, 32'h0520);
        wr_reg(6'd0, 16'h0500);
        chk("R4", reg_rdata, 32'h0020);
        chk("R5", {31'b0, sci}, 32'h0);

        // R6/R7: control and suspend types
        for (int t = 0; t < 4; t++) begin
            wr_reg(6'd4, 16'h2001 | 16'(t << 10));
            chk("R6", reg_rdata, 32'h0001 | 32'(t << 10));
            chk("R7", {31'b0, soft_off}, {31'b0, t == 0});
            cyc();
        end
        wr_reg(6'd4, 16'h0000);
        chk("R7", {31'b0, soft_off}, 32'h0);

        // R8: APM port
        apm_wr = 1; apm_sel = 0; apm_wdata = 8'h5A; smi_cfg_en = 0; cyc(); quiet();
        chk("R8", {31'b0, smi}, 32'h0);
        smi_cfg_en = 1; apm_wr = 1; apm_wdata = 8'hC3; cyc(); quiet();
        chk("R8", {31'b0, smi}, 32'h1);
        apm_wr = 1; apm_sel = 1; apm_wdata = 8'h77; cyc(); quiet();
        chk("R8", {31'b0, smi}, 32'h0);
        chk("R8", {24'b0, apm_rdata}, 32'h77);

        // R9: unmapped and timer writes change nothing
        wr_reg(6'd8, 16'hFFFF);
        wr_reg(6'd6, 16'hFFFF);
        chk("R9", reg_rdata, 32'h0);
        reg_addr = 6'd2; #1;
        chk("R9", reg_rdata, 32'h0100);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            tick       = ($urandom % 4) != 0;
            rtc_evt    = ($urandom % 16) == 0;
            pwrbtn_evt = ($urandom % 16) == 0;
            gbl_evt    = ($urandom % 16) == 0;
            reg_wr     = ($urandom % 6) == 0;
            reg_addr   = 6'(2 * ($urandom % 7));
            reg_wdata  = 16'($urandom);
            apm_wr     = ($urandom % 8) == 0;
            apm_sel    = $urandom % 2;
            apm_wdata  = 8'($urandom);
            smi_cfg_en = $urandom % 2;
            cyc();
        end
        quiet();
        cyc();
        finish_run();
    end
endmodule